// File: doc/BRIEF.md
# Programmable Field Vertical Sync Generator

This block places the vertical sync pulse of an interlaced video field. A line counter and two strobes, one at the start of each line and one at mid-line, give it a time base in half-line steps. Two 8-bit edge words set where the pulse rises and where it falls. Each word has a line offset and a direction bit. It also has two per-field delay bits, one for each field parity. A 4-bit half-line word can pull either edge back by half a line, with a separate bit for each edge and each parity.

The edge words, the half-line word and the parity flag are latched only when a field starts. A field starts on the line-start strobe of line 0, so each field uses one consistent set of edge positions. The block drives a VSYNC output and a V flag. The V flag feeds an embedded timing-code inserter. The two outputs come from the same state and always agree.

Top module: `vsync_timing_gen`

## Requirements
- R1: After reset, `vsync` and `v_flag` are 0. Until the first field start, the latched settings are: begin word 0x25 (offset 5, advance), end word 0x03 (offset 3, delay), half-line word 0, parity even.
- R2: In an edge word, bits [4:0] are the offset in lines and bit 5 is the direction. Direction 0 places the edge offset lines after the nominal line. Direction 1 places it offset lines before. The nominal lines are parameters `NOM_BEGIN` and `NOM_END`.
- R3: In an edge word, bit 7 (odd field) or bit 6 (even field) adds one more line of delay to that edge. The latched parity selects which of the two bits applies.
- R4: The half-line word has four bits: bit 0 for the begin edge on even fields, bit 1 for the begin edge on odd fields, bit 2 for the end edge on even fields, bit 3 for the end edge on odd fields. A set bit moves that edge from the line start of line L to the mid-line of line L-1.
- R5: The line-start strobe at line L marks half-line position 2L. The mid-line strobe marks position 2L+1. If both strobes are high in one cycle, the line-start strobe wins.
- R6: `vsync` goes high in the cycle after the event at the adjusted begin position. It goes low in the cycle after the event at the adjusted end position.
- R7: If the adjusted end position is not later than the adjusted begin position, `vsync` stays low for the whole field.
- R8: A field start clears `vsync` and latches the edge words, the half-line word and the parity flag. Changes to these inputs at any other time have no effect on the current field.
- R9: `v_flag` equals `vsync` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| half_line | input | 1 | One-cycle strobe at mid-line |
| line_num | input | LINE_W | Line number within the field |
| field_odd | input | 1 | Field parity, 1 = odd |
| begin_cfg | input | 8 | Rising-edge word |
| end_cfg | input | 8 | Falling-edge word |
| half_cfg | input | 4 | Per-edge, per-parity half-line advance |
| vsync | output | 1 | Vertical sync output |
| v_flag | output | 1 | V flag for the timing-code inserter |

## Verification
The assertions check four things on every cycle:
- A rise of `vsync` always comes from an event at the computed begin position.
- A fall always comes from an event at the computed end position, or from a field start.
- A field with an empty window never raises `vsync`.
- The latched settings change only at a field start.

Whether the computed positions match the arithmetic of the edge words can only be shown by the bench's sweeps. The same holds for the parity selection of the delay and half-line bits, the reset defaults, and whether writes in mid-field are ignored. Those sweeps cover all 256 values of each edge word under both parities.

// File: rtl/vsync_pkg.sv
package vsync_pkg;

  localparam int POS_W = 16;

  typedef struct packed {
    logic       odd_dly;
    logic       even_dly;
    logic       advance;
    logic [4:0] ofs;
  } edge_cfg_t;

  typedef logic signed [POS_W-1:0] hpos_t;

  // Half-line position of an edge from its nominal line and settings.
  function automatic hpos_t edge_half_pos(input int nominal, input edge_cfg_t c,
                                          input logic odd, input logic half_adv);
    int lines;
    lines = nominal;
    if (c.advance) lines = lines - int'(c.ofs);
    else           lines = lines + int'(c.ofs);
    if (odd ? c.odd_dly : c.even_dly) lines = lines + 1;
    return hpos_t'(2 * lines - (half_adv ? 1 : 0));
  endfunction

endpackage

// File: rtl/vsync_cfg_shadow.sv
module vsync_cfg_shadow
  import vsync_pkg::*;
#(
  parameter logic [7:0] RST_BEGIN = 8'h25,
  parameter logic [7:0] RST_END   = 8'h03
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  logic [7:0] begin_cfg,
  input  logic [7:0] end_cfg,
  input  logic [3:0] half_cfg,
  input  logic      field_odd,
  output edge_cfg_t beg_q,
  output edge_cfg_t end_q,
  output logic [3:0] half_q,
  output logic      odd_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beg_q  <= edge_cfg_t'(RST_BEGIN);
      end_q  <= edge_cfg_t'(RST_END);
      half_q <= '0;
      odd_q  <= 1'b0;
    end else if (load) begin
      beg_q  <= edge_cfg_t'(begin_cfg);
      end_q  <= edge_cfg_t'(end_cfg);
      half_q <= half_cfg;
      odd_q  <= field_odd;
    end
  end

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(beg_q) && $stable(end_q) && $stable(half_q) && $stable(odd_q)));

endmodule

// File: rtl/vsync_strobe_pos.sv
module vsync_strobe_pos
  import vsync_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic              line_start,
  input  logic              half_line,
  input  logic [LINE_W-1:0] line_num,
  output logic              evt_valid,
  output hpos_t             evt_pos,
  output logic              field_start
);

  logic [POS_W-1:0] base;

  always_comb begin
    base        = POS_W'(line_num) << 1;
    evt_valid   = line_start | half_line;
    evt_pos     = hpos_t'(base | POS_W'(!line_start));
    field_start = line_start && (line_num == '0);
  end

endmodule

// File: rtl/vsync_edge_calc.sv
module vsync_edge_calc
  import vsync_pkg::*;
#(
  parameter int NOM_BEGIN = 9,
  parameter int NOM_END   = 4
) (
  input  edge_cfg_t  beg_q,
  input  edge_cfg_t  end_q,
  input  logic [3:0] half_q,
  input  logic       odd_q,
  output hpos_t      beg_pos,
  output hpos_t      end_pos,
  output logic       pulse_ok
);

  localparam int NUM_EDGES = 2;

  edge_cfg_t cfg_a [NUM_EDGES];
  hpos_t     pos_a [NUM_EDGES];
  logic [NUM_EDGES-1:0] hsel;

  assign cfg_a[0] = beg_q;
  assign cfg_a[1] = end_q;

  for (genvar g = 0; g < NUM_EDGES; g++) begin : g_edge
    localparam int NOM = (g == 0) ? NOM_BEGIN : NOM_END;
    assign hsel[g]  = odd_q ? half_q[2*g+1] : half_q[2*g];
    assign pos_a[g] = edge_half_pos(NOM, cfg_a[g], odd_q, hsel[g]);
  end

  assign beg_pos  = pos_a[0];
  assign end_pos  = pos_a[1];
  assign pulse_ok = (end_pos > beg_pos);

endmodule

// File: rtl/vsync_timing_gen.sv
module vsync_timing_gen
  import vsync_pkg::*;
#(
  parameter int         LINE_W    = 10,
  parameter int         NOM_BEGIN = 9,
  parameter int         NOM_END   = 4,
  parameter logic [7:0] RST_BEGIN = 8'h25,
  parameter logic [7:0] RST_END   = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              half_line,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_odd,
  input  logic [7:0]        begin_cfg,
  input  logic [7:0]        end_cfg,
  input  logic [3:0]        half_cfg,
  output logic              vsync,
  output logic              v_flag
);

  logic       evt_valid;
  hpos_t      evt_pos;
  logic       field_start;
  edge_cfg_t  beg_q, end_q;
  logic [3:0] half_q;
  logic       odd_q;
  hpos_t      beg_pos, end_pos;
  logic       pulse_ok;
  logic       hit_begin, hit_end;
  logic       vs_q;

  vsync_strobe_pos #(.LINE_W(LINE_W)) i_pos (
    .line_start (line_start),
    .half_line  (half_line),
    .line_num   (line_num),
    .evt_valid  (evt_valid),
    .evt_pos    (evt_pos),
    .field_start(field_start)
  );

  vsync_cfg_shadow #(.RST_BEGIN(RST_BEGIN), .RST_END(RST_END)) i_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (field_start),
    .begin_cfg(begin_cfg),
    .end_cfg  (end_cfg),
    .half_cfg (half_cfg),
    .field_odd(field_odd),
    .beg_q    (beg_q),
    .end_q    (end_q),
    .half_q   (half_q),
    .odd_q    (odd_q)
  );

  vsync_edge_calc #(.NOM_BEGIN(NOM_BEGIN), .NOM_END(NOM_END)) i_calc (
    .beg_q   (beg_q),
    .end_q   (end_q),
    .half_q  (half_q),
    .odd_q   (odd_q),
    .beg_pos (beg_pos),
    .end_pos (end_pos),
    .pulse_ok(pulse_ok)
  );

  assign hit_begin = evt_valid && (evt_pos == beg_pos) && pulse_ok;
  assign hit_end   = evt_valid && (evt_pos == end_pos);

  always_ff @(posedge clk) begin
    if (!rst_n)          vs_q <= 1'b0;
    else if (field_start) vs_q <= 1'b0;
    else if (hit_end)    vs_q <= 1'b0;
    else if (hit_begin)  vs_q <= 1'b1;
  end

  assign vsync  = vs_q;
  assign v_flag = vs_q;

  assert_rise_at_begin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_q) |-> $past(evt_valid && (evt_pos == beg_pos) && !field_start));

  assert_fall_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vs_q) |-> $past(field_start || (evt_valid && (evt_pos == end_pos))));

  assert_empty_window_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_ok && !vs_q) |=> !vs_q);

  assert_field_start_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> !vs_q);

endmodule

// File: tb/test_vsync_timing_gen.sv
module test_vsync_timing_gen;

  localparam int LINE_W = 10;
  localparam int NB     = 9;
  localparam int NE     = 4;
  localparam int LINES  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic line_start, half_line, field_odd;
  logic [LINE_W-1:0] line_num;
  logic [7:0] begin_cfg, end_cfg;
  logic [3:0] half_cfg;
  logic vsync, v_flag;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Bench model of the latched field.
  int mb, me;
  bit mok;
  bit exp_vs;

  always #2 clk = ~clk;

  vsync_timing_gen #(.LINE_W(LINE_W), .NOM_BEGIN(NB), .NOM_END(NE)) i_vsync_timing_gen (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .half_line(half_line),
    .line_num(line_num), .field_odd(field_odd), .begin_cfg(begin_cfg),
    .end_cfg(end_cfg), .half_cfg(half_cfg), .vsync(vsync), .v_flag(v_flag)
  );

  function automatic int mpos(input int nom, input logic [7:0] c, input bit odd, input bit h);
    int delta, extra;
    delta = c[5] ? -int'(c[4:0]) : int'(c[4:0]);
    extra = odd ? int'(c[7]) : int'(c[6]);
    return 2 * (nom + delta + extra) - int'(h);
  endfunction

  task automatic check(input logic act, input logic expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, expv);
    end
  endtask

  // One strobe event; ls=1 line start, ls=0 mid-line, both=1 drives both.
  task automatic ev(input bit ls, input bit both, input int ln, input string tag);
    int p;
    @(negedge clk);
    line_start = ls;
    half_line  = !ls || both;
    line_num   = LINE_W'(ln);
    p = ls ? 2 * ln : 2 * ln + 1;
    if (ls && ln == 0) begin
      // R8: field start latches inputs and clears the output
      mb = mpos(NB, begin_cfg, field_odd, field_odd ? half_cfg[1] : half_cfg[0]);
      me = mpos(NE, end_cfg,   field_odd, field_odd ? half_cfg[3] : half_cfg[2]);
      mok = (me > mb);
      exp_vs = 1'b0;
    end else if (p == me) exp_vs = 1'b0;
    else if (mok && p == mb) exp_vs = 1'b1;
    @(posedge clk); #1;
    line_start = 1'b0;
    half_line  = 1'b0;
    check(vsync, exp_vs, mok ? tag : "R7 empty window");
    check(v_flag, vsync, "R9 v_flag vs vsync");
    @(negedge clk);
    check(vsync, exp_vs, "R6 hold between events");
  endtask

  // One field; next-field settings are written in mid-field (R8).
  task automatic field(input logic [7:0] nb, input logic [7:0] ne,
                       input logic [3:0] nh, input bit nodd);
    for (int ln = 0; ln < LINES; ln++) begin
      ev(1'b1, 1'b0, ln, "R2 R3 R4 R5 R6 R8 position");
      if (ln == LINES / 2) begin
        begin_cfg = nb; end_cfg = ne; half_cfg = nh; field_odd = nodd;
      end
      ev(1'b0, 1'b0, ln, "R2 R3 R4 R5 R6 R8 position");
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; line_start = 0; half_line = 0; line_num = '0;
    field_odd = 1'b1; begin_cfg = 8'hFF; end_cfg = 8'h00; half_cfg = 4'hF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    check(vsync, 1'b0, "R1 reset vsync");
    check(v_flag, 1'b0, "R1 reset v_flag");
    // R1: reset defaults in force before any field start
    mb = mpos(NB, 8'h25, 1'b0, 1'b0);
    me = mpos(NE, 8'h03, 1'b0, 1'b0);
    mok = (me > mb);
    exp_vs = 1'b0;
    for (int ln = 1; ln < LINES; ln++) begin
      ev(1'b1, 1'b0, ln, "R1 default positions");
      ev(1'b0, 1'b0, ln, "R1 default positions");
    end
    // R5: both strobes at once count as line start
    begin_cfg = 8'h07; end_cfg = 8'h00; half_cfg = 4'h0; field_odd = 1'b0;
    ev(1'b1, 1'b0, 0, "R8 field start");
    for (int ln = 1; ln < LINES; ln++)
      ev(1'b1, 1'b1, ln, "R5 both strobes");
    // Sweep begin word over all values, both parities
    begin_cfg = 8'h00; end_cfg = 8'h08; half_cfg = 4'h0; field_odd = 1'b0;
    for (int v = 0; v < 256; v++)
      for (int f = 0; f < 2; f++)
        field(8'(v), 8'h08, 4'(v) ^ 4'(v >> 4), f[0]);
    // Sweep end word over all values, both parities
    for (int v = 0; v < 256; v++)
      for (int f = 0; f < 2; f++)
        field(8'h03 ^ 8'(v >> 6), 8'(v), 4'(v >> 2), f[0]);
    field(8'h00, 8'h00, 4'h0, 1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule